// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between a processor bus and the program/erase engine of a NOR flash. It watches bus writes, compares their address and low data byte against the expected unlock pairs and command bytes, and turns valid sequences into one-cycle requests for word programming, single-block erase or full-chip erase. Each request carries the latched target address, the word to program and the 3-bit block index.

A read selector tells the surrounding read path what to drive on the data bus. It can drive the storage array, an identification word that the block supplies, or a status byte that the block supplies. Both the selector and the word are captured on each bus-read strobe. A ready flag goes low while the engine works. The engine ends an operation with a done pulse that carries an error flag. After an error, the block keeps presenting status until a reset command arrives. Operations that change the array are dropped unless the programming supply is at its high-voltage level.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, rdy is 1, progReq, blkEraseReq and chipEraseReq are 0, and a bus read gives rdSel = 0 (array).
- R2: A single write with data byte F0h at any address returns the block to read mode. So does the three-write sequence AAh@555h, 55h@2AAh, F0h@555h.
- R3: After AAh@555h, 55h@2AAh, 90h@555h, reads give rdSel = 1. rdWord is 0020h when address bits [1:0] = 00 and 88ABh when they are 01. Address bits 19..2 are ignored in this decode.
- R4: The identification mode lasts until an F0h write. Every other write sequence, including a complete program sequence, is ignored and issues no request.
- R5: The program sequence is AAh@555h, 55h@2AAh, A0h@555h, then a write carrying the target address and word. With the supply at the high-voltage level, the cycle after that last write shows progReq = 1 for exactly one cycle, with opAddr and opData holding that write's address and word.
- R6: The erase preamble is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh. After it, a sixth write of 30h at any address pulses blkEraseReq, with opBlk equal to address bits 19..17 of that write. A sixth write of 10h@555h pulses chipEraseReq.
- R7: When vppLvl is not 2 (high-voltage) at the final write, no request is issued, rdy stays 1 and the block returns to read mode. Encoding of vppLvl: 0 low, 1 logic high, 2 high-voltage.
- R8: A write that does not fit the sequence in progress returns the block to read mode. Later writes must then start a fresh sequence.
- R9: From a request until engDone, rdy is 0, every write (including F0h) is ignored, and reads give rdSel = 2 with rdWord = 0000h.
- R10: engDone with engErr = 0 returns the block to read mode with rdy = 1. With engErr = 1, reads keep giving rdSel = 2 and rdWord = 00A0h (bit 7 ready, bit 5 error) until an F0h write.
- R11: An F0h write between the unlock and command writes of a sequence abandons that sequence.
- R12: Command matching looks only at address bits 10..0 and data bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Bus write strobe, one cycle per write |
| rdStb | input | 1 | Bus read strobe, one cycle per read |
| busAddr | input | 20 | Bus address |
| busData | input | 16 | Bus write data |
| vppLvl | input | 2 | Programming supply level: 0 low, 1 high, 2 high-voltage |
| engDone | input | 1 | Engine finished pulse |
| engErr | input | 1 | Engine error, valid with engDone |
| progReq | output | 1 | Word program request pulse |
| blkEraseReq | output | 1 | Block erase request pulse |
| chipEraseReq | output | 1 | Chip erase request pulse |
| opAddr | output | 20 | Latched operation address |
| opData | output | 16 | Latched program word |
| opBlk | output | 3 | Latched block index |
| rdy | output | 1 | 1 when ready, 0 while an operation runs |
| rdSel | output | 2 | Read source: 0 array, 1 identification, 2 status |
| rdWord | output | 16 | Identification or status word for the current read |

## Verification
Block erase is swept over all eight blocks, which separates correct use of the top address bits from a fixed or shifted block index. Each of the three array-changing commands is tried at every supply level, which separates gating at the final write from no gating or gating on the wrong command. Identification reads are swept over several values of the upper address bits, so a decode that leaks those bits shows up. Broken sequences, early F0h writes, commands sent while busy and commands sent in identification mode each check that a request is issued only by a complete, well-formed sequence.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PGM, S_ERS3, S_ERS4, S_ERS5, S_AUTO, S_BUSY, S_FAIL
  } seqState_t;

  typedef enum logic [1:0] {SEL_ARRAY = 2'd0, SEL_ID = 2'd1, SEL_STATUS = 2'd2} rdSel_t;

  localparam logic [1:0] VPP_VHH = 2'd2;

  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_AUTO  = 8'h90;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_BLOCK = 8'h30;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic atKey;
    logic isReset;
    logic isAuto;
    logic isProg;
    logic isErase;
    logic isChip;
    logic isBlock;
  } decode_t;

  typedef struct packed {
    logic   latchOp;
    logic   capRead;
    rdSel_t selNow;
    logic   busyNow;
    logic   failNow;
  } strobe_t;
endpackage

// File: rtl/fcs_dpath.sv
module fcs_dpath
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 11,
  parameter int BLK_W  = 3,
  parameter logic [CMP_W-1:0] KEY1_ADDR = 11'h555,
  parameter logic [7:0]       KEY1_DATA = 8'hAA,
  parameter logic [CMP_W-1:0] KEY2_ADDR = 11'h2AA,
  parameter logic [7:0]       KEY2_DATA = 8'h55,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h0020,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h88AB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  strobe_t           stb,
  output decode_t           dec,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [BLK_W-1:0]  opBlk,
  output logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdWord
);
  localparam int CMD_W = 8;

  logic [CMP_W-1:0] keyAddr;
  logic [CMD_W-1:0] cmdByte;
  logic [DATA_W-1:0] idWord, statWord, nextWord;

  assign keyAddr = busAddr[CMP_W-1:0];
  assign cmdByte = busData[CMD_W-1:0];

  always_comb begin
    dec.unl1    = (keyAddr == KEY1_ADDR) && (cmdByte == KEY1_DATA);
    dec.unl2    = (keyAddr == KEY2_ADDR) && (cmdByte == KEY2_DATA);
    dec.atKey   = (keyAddr == KEY1_ADDR);
    dec.isReset = (cmdByte == CMD_RESET);
    dec.isAuto  = (cmdByte == CMD_AUTO);
    dec.isProg  = (cmdByte == CMD_PROG);
    dec.isErase = (cmdByte == CMD_ERASE);
    dec.isChip  = (cmdByte == CMD_CHIP);
    dec.isBlock = (cmdByte == CMD_BLOCK);
  end

  always_comb begin
    idWord = '0;
    if (!busAddr[1]) idWord = busAddr[0] ? DEV_ID : MFR_ID;
    statWord = '0;
    statWord[7] = ~stb.busyNow;
    statWord[5] = stb.failNow;
    case (stb.selNow)
      SEL_ID:     nextWord = idWord;
      SEL_STATUS: nextWord = statWord;
      default:    nextWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
      opBlk  <= '0;
      rdSel  <= SEL_ARRAY;
      rdWord <= '0;
    end else begin
      if (stb.latchOp) begin
        opAddr <= busAddr;
        opData <= busData;
        opBlk  <= busAddr[ADDR_W-1 -: BLK_W];
      end
      if (stb.capRead) begin
        rdSel  <= stb.selNow;
        rdWord <= nextWord;
      end
    end
  end
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic [1:0] vppLvl,
  input  logic       engDone,
  input  logic       engErr,
  input  decode_t    dec,
  output strobe_t    stb,
  output logic       progReq,
  output logic       blkEraseReq,
  output logic       chipEraseReq,
  output logic       rdy
);
  seqState_t state, nextState;
  logic vppOk, startProg, startBlk, startChip;

  assign vppOk = (vppLvl == VPP_VHH);

  always_comb begin
    nextState = state;
    startProg = 1'b0;
    startBlk  = 1'b0;
    startChip = 1'b0;
    case (state)
      S_BUSY: if (engDone) nextState = engErr ? S_FAIL : S_READ;
      S_FAIL: if (wrStb && dec.isReset) nextState = S_READ;
      S_AUTO: if (wrStb && dec.isReset) nextState = S_READ;
      S_READ: if (wrStb && dec.unl1) nextState = S_UNL1;
      S_UNL1: if (wrStb) nextState = (!dec.isReset && dec.unl2) ? S_UNL2 : S_READ;
      S_UNL2: if (wrStb) begin
        nextState = S_READ;
        if (dec.atKey && dec.isAuto)  nextState = S_AUTO;
        if (dec.atKey && dec.isProg)  nextState = S_PGM;
        if (dec.atKey && dec.isErase) nextState = S_ERS3;
      end
      S_PGM: if (wrStb) begin
        startProg = vppOk;
        nextState = vppOk ? S_BUSY : S_READ;
      end
      S_ERS3: if (wrStb) nextState = (!dec.isReset && dec.unl1) ? S_ERS4 : S_READ;
      S_ERS4: if (wrStb) nextState = (!dec.isReset && dec.unl2) ? S_ERS5 : S_READ;
      S_ERS5: if (wrStb) begin
        startChip = vppOk && dec.atKey && dec.isChip;
        startBlk  = vppOk && dec.isBlock;
        nextState = (startChip || startBlk) ? S_BUSY : S_READ;
      end
      default: nextState = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_READ;
      progReq      <= 1'b0;
      blkEraseReq  <= 1'b0;
      chipEraseReq <= 1'b0;
    end else begin
      state        <= nextState;
      progReq      <= startProg;
      blkEraseReq  <= startBlk;
      chipEraseReq <= startChip;
    end
  end

  always_comb begin
    stb.latchOp = startProg || startBlk || startChip;
    stb.capRead = rdStb;
    stb.busyNow = (state == S_BUSY);
    stb.failNow = (state == S_FAIL);
    case (state)
      S_AUTO:         stb.selNow = SEL_ID;
      S_BUSY, S_FAIL: stb.selNow = SEL_STATUS;
      default:        stb.selNow = SEL_ARRAY;
    endcase
  end

  assign rdy = (state != S_BUSY);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [1:0]        vppLvl,
  input  logic              engDone,
  input  logic              engErr,
  output logic              progReq,
  output logic              blkEraseReq,
  output logic              chipEraseReq,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [BLK_W-1:0]  opBlk,
  output logic              rdy,
  output logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdWord
);
  decode_t dec;
  strobe_t stb;

  fcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .vppLvl(vppLvl),
    .engDone(engDone), .engErr(engErr), .dec(dec), .stb(stb),
    .progReq(progReq), .blkEraseReq(blkEraseReq), .chipEraseReq(chipEraseReq), .rdy(rdy)
  );

  fcs_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .stb(stb), .dec(dec),
    .opAddr(opAddr), .opData(opData), .opBlk(opBlk), .rdSel(rdSel), .rdWord(rdWord)
  );
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrStb,
  input logic       rdStb,
  input logic [1:0] vppLvl,
  input logic       engDone,
  input logic       progReq,
  input logic       blkEraseReq,
  input logic       chipEraseReq,
  input logic       rdy,
  input logic [1:0] rdSel
);
  logic anyReq;
  assign anyReq = progReq || blkEraseReq || chipEraseReq;

  p_req_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, blkEraseReq, chipEraseReq}));

  p_req_needs_vhh_r7: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> ($past(vppLvl) == 2'd2 && $past(wrStb)));

  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> !rdy);

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdy && !engDone) |=> !rdy);

  p_no_req_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |=> !anyReq);

  p_busy_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !rdy) |=> (rdSel == 2'd2));

  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!rdy && engDone) |=> rdy);
endmodule

bind flash_cmd_seq fcs_chk u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .vppLvl(vppLvl),
  .engDone(engDone), .progReq(progReq), .blkEraseReq(blkEraseReq),
  .chipEraseReq(chipEraseReq), .rdy(rdy), .rdSel(rdSel)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0, rdStb = 1'b0;
  logic [19:0] busAddr = '0;
  logic [15:0] busData = '0;
  logic [1:0]  vppLvl = 2'd2;
  logic        engDone = 1'b0, engErr = 1'b0;
  logic        progReq, blkEraseReq, chipEraseReq, rdy;
  logic [19:0] opAddr;
  logic [15:0] opData;
  logic [2:0]  opBlk;
  logic [1:0]  rdSel;
  logic [15:0] rdWord;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  flash_cmd_seq u0 (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [15:0] d);
    @(negedge clk); wrStb = 1'b1; busAddr = a; busData = d;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic rd(logic [19:0] a);
    @(negedge clk); rdStb = 1'b1; busAddr = a;
    @(negedge clk); rdStb = 1'b0;
  endtask

  task automatic finishOp(logic e);
    @(negedge clk); engDone = 1'b1; engErr = e;
    @(negedge clk); engDone = 1'b0; engErr = 1'b0;
  endtask

  task automatic unlock(logic [19:0] hi);
    wr(hi | 20'h555, 16'h00AA); wr(hi | 20'h2AA, 16'h0055);
  endtask

  task automatic doProg(logic [19:0] a, logic [15:0] d);
    unlock(0); wr(20'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic erasePre();
    unlock(0); wr(20'h555, 16'h0080); unlock(0);
  endtask

  task automatic noReq(string tag);
    check(tag, {progReq, blkEraseReq, chipEraseReq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdy", rdy, 1); noReq("R1 req");
    rd(20'h00000); check("R1 rdSel", rdSel, 0);

    // R5 program at VHH
    doProg(20'h12345, 16'hBEEF);
    check("R5 progReq", progReq, 1); check("R5 opAddr", opAddr, 20'h12345);
    check("R5 opData", opData, 16'hBEEF); check("R9 rdy low", rdy, 0);
    @(negedge clk); check("R5 one-cycle pulse", progReq, 0);
    // R9 busy behaviour
    rd(20'h00000); check("R9 rdSel", rdSel, 2); check("R9 rdWord", rdWord, 0);
    wr(20'h00555, 16'h00F0); check("R9 reset ignored", rdy, 0);
    doProg(20'h00001, 16'h0000); noReq("R9 cmd ignored");
    rd(20'h00001); check("R9 still status", rdSel, 2);
    // R10 success
    finishOp(1'b0); check("R10 rdy", rdy, 1);
    rd(20'h00000); check("R10 array", rdSel, 0);

    // R6 block erase sweep over all blocks
    for (int b = 0; b < 8; b++) begin
      erasePre(); wr({b[2:0], 17'h0ABC}, 16'h0030);
      check("R6 blkEraseReq", blkEraseReq, 1);
      check("R6 opBlk", opBlk, b[2:0]);
      finishOp(1'b0);
    end
    erasePre(); wr(20'h00555, 16'h0010);
    check("R6 chipEraseReq", chipEraseReq, 1);
    finishOp(1'b0);

    // R7 supply gating at each non-VHH level, all three commands
    for (int lv = 0; lv < 2; lv++) begin
      vppLvl = lv[1:0];
      doProg(20'h00010, 16'h1234); noReq("R7 prog"); check("R7 rdy", rdy, 1);
      erasePre(); wr(20'h40000, 16'h0030); noReq("R7 blk");
      erasePre(); wr(20'h00555, 16'h0010); noReq("R7 chip");
      rd(20'h00000); check("R7 array", rdSel, 0);
      vppLvl = 2'd2;
      doProg(20'h00020, 16'h0F0F); check("R7 back to read", progReq, 1);
      finishOp(1'b0);
    end

    // R10 error latches status
    doProg(20'h00030, 16'h5555); finishOp(1'b1);
    check("R10 err rdy", rdy, 1);
    rd(20'h00000); check("R10 err sel", rdSel, 2); check("R10 err word", rdWord, 16'h00A0);
    wr(20'h00555, 16'h00AA);
    rd(20'h00000); check("R10 err held", rdSel, 2);
    wr(20'h0F000, 16'h00F0);
    rd(20'h00000); check("R10 cleared", rdSel, 0);

    // R3 identification reads across upper address bits
    unlock(0); wr(20'h00555, 16'h0090);
    foreach (busData[i]) if (i < 4) begin
      logic [19:0] hi;
      hi = {i[17:0], 2'b00} * 20'h1111 & 20'hFFFFC;
      rd(hi);          check("R3 sel", rdSel, 1); check("R3 mfr", rdWord, 16'h0020);
      rd(hi | 20'h1);  check("R3 dev", rdWord, 16'h88AB);
    end
    // R4 commands ignored in identification mode
    doProg(20'h00040, 16'h0001); noReq("R4 prog ignored");
    erasePre(); wr(20'h00555, 16'h0010); noReq("R4 chip ignored");
    rd(20'h00000); check("R4 still id", rdSel, 1);
    // R2 single-write reset
    wr(20'h7ABCD, 16'h00F0);
    rd(20'h00000); check("R2 single reset", rdSel, 0);

    // R2 three-write reset
    unlock(0); wr(20'h00555, 16'h00F0);
    wr(20'h00555, 16'h00A0); wr(20'h00100, 16'h1234);
    noReq("R2 three-write reset"); check("R2 rdy", rdy, 1);

    // R8 broken sequence
    wr(20'h00555, 16'h00AA); wr(20'h002AB, 16'h0055);
    wr(20'h00555, 16'h00A0); wr(20'h00200, 16'h0000);
    noReq("R8 broken addr");
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0056);
    wr(20'h00555, 16'h0080); unlock(0); wr(20'h20000, 16'h0030);
    noReq("R8 broken data");
    rd(20'h00000); check("R8 array", rdSel, 0);

    // R11 reset between writes
    unlock(0); wr(20'h00555, 16'h0080); wr(20'h00555, 16'h00AA);
    wr(20'h00123, 16'h00F0); wr(20'h002AA, 16'h0055); wr(20'h20000, 16'h0030);
    noReq("R11 abandoned");

    // R12 upper address bits ignored in matching
    unlock(20'hFF000); wr(20'h3A555, 16'hC3A0); wr(20'h54321, 16'h00FF);
    check("R12 progReq", progReq, 1); check("R12 opAddr", opAddr, 20'h54321);
    finishOp(1'b0);

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule